// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer behind a small register bus. A down-counter is advanced by a tick that comes from two stages in series. The first stage is a programmable prescaler that divides the clock by P+1. The second stage is a power-of-two divider that divides by 16, 32, 64 or 128. If software stops servicing the counter and it runs out, the block raises a sticky interrupt, a fixed-length reset request, or both. Each output has its own enable bit.

Software arms the timer by writing a reload value and the control word. It keeps the system alive by rewriting the count register before the count runs out. It acknowledges an interrupt by writing any value to a write-only clear register. While a debugger holds the debug-acknowledge input high, a mask bit in the control word keeps both outputs quiet.

Top module: `wdt_prescaled`

## Requirements
- R1: After reset, the control register reads 0, the reload register reads 0x8000 and the count register reads 0x8000, and both the interrupt and the reset request are low.
- R2: Word offsets select the registers: 0x0 is control, 0x4 is reload, 0x8 is count and 0xC is the interrupt clear. Reads of 0xC return 0. The control fields are: bit 0 reset enable, bit 2 interrupt enable, bits 4:3 divider select, bit 5 timer enable, bits 15:8 prescale value P, and bit 16 debug mask. All other control bits read as 0.
- R3: While the timer is enabled, one count tick occurs every (P+1)·(16<<S) clocks, where S is the divider select. The first tick comes that many clocks after the control write that sets the enable bit.
- R4: Each tick decrements the count by one. A tick that finds the count at 0 is an expiry, and it reloads the count from the reload register in the same cycle. A count of N therefore expires on the (N+1)-th tick.
- R5: On an expiry with interrupt enable set, an interrupt flag is set. The flag stays set until a write to the clear register that does not coincide with a new expiry.
- R6: On an expiry with reset enable set, the reset request goes high for exactly 128 clocks.
- R7: A write to the count register loads the counter directly and takes priority over a tick in the same cycle. This write is the keepalive.
- R8: While the enable bit is clear, the count holds its value. Clearing the enable bit also resets the prescaler and divider, so a later enable starts a full tick period.
- R9: While the debug mask bit and the debug-acknowledge input are both high, the interrupt and the reset request are held low. The interrupt flag is kept and shows again once the mask condition ends.
- R10: An expiry with interrupt enable clear sets no flag. An expiry with reset enable clear produces no reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the counter source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | 4 | Byte address; bits 3:2 select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| dbg_ack | input | 1 | Debug-acknowledge from the processor |
| irq | output | 1 | Interrupt request, level |
| rst_req | output | 1 | Reset request pulse |

## Verification
The bench draws random prescale values, divider selects and load counts, then checks that the interrupt is still low one clock before the predicted expiry and high on that clock. An off-by-one in either stage, or a divider that ignores its select, shifts that edge and is caught. Directed cases cover the remaining corners:
- A keepalive written on the very clock of a tick: a design that lets the tick win loses a count and fires early.
- A re-enable after a partial prescale: leftover divider state also fires early.
- A full 128-clock reset pulse: a counter that is off by one gives a pulse of 127 or 129 clocks.
- The debug mask: a design that clears the flag instead of hiding it loses the pending interrupt.

// File: rtl/wdt_prescaled.sv
module wdt_prescaled #(
  parameter int CNT_W      = 16,
  parameter int PRE_W      = 8,
  parameter int RST_CYCLES = 128,
  parameter int RESET_LOAD = 32'h8000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        dbg_ack,
  output logic        irq,
  output logic        rst_req
);
  localparam int DIV_W = 7;
  localparam int RC_W  = $clog2(RST_CYCLES + 1);

  logic             r_rst_en, r_irq_en, r_en, r_dbgmask;
  logic [1:0]       r_div;
  logic [PRE_W-1:0] r_pre;
  logic [CNT_W-1:0] data_q, cnt_q;
  logic [PRE_W-1:0] pre_cnt;
  logic [DIV_W-1:0] div_cnt, div_last;
  logic [RC_W-1:0]  rst_left;
  logic             irq_flag;
  logic             wr_ctrl, wr_data, wr_cnt, wr_clr;
  logic             pre_tick, tick, expire, muted;

  assign wr_ctrl  = bus_sel & bus_wr & (bus_addr[3:2] == 2'd0);
  assign wr_data  = bus_sel & bus_wr & (bus_addr[3:2] == 2'd1);
  assign wr_cnt   = bus_sel & bus_wr & (bus_addr[3:2] == 2'd2);
  assign wr_clr   = bus_sel & bus_wr & (bus_addr[3:2] == 2'd3);

  assign div_last = DIV_W'((8'd16 << r_div) - 8'd1);
  assign pre_tick = r_en & (pre_cnt == r_pre);
  assign tick     = pre_tick & ((div_cnt & div_last) == div_last);
  assign expire   = tick & (cnt_q == '0) & ~wr_cnt;
  assign muted    = r_dbgmask & dbg_ack;
  assign irq      = irq_flag & ~muted;
  assign rst_req  = (rst_left != '0) & ~muted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_rst_en  <= 1'b0;
      r_irq_en  <= 1'b0;
      r_en      <= 1'b0;
      r_dbgmask <= 1'b0;
      r_div     <= '0;
      r_pre     <= '0;
    end else if (wr_ctrl) begin
      r_rst_en  <= bus_wdata[0];
      r_irq_en  <= bus_wdata[2];
      r_div     <= bus_wdata[4:3];
      r_en      <= bus_wdata[5];
      r_pre     <= bus_wdata[8 +: PRE_W];
      r_dbgmask <= bus_wdata[16];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else if (!r_en) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else if (pre_tick) begin
      pre_cnt <= '0;
      div_cnt <= div_cnt + 1'b1;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= CNT_W'(RESET_LOAD);
      cnt_q  <= CNT_W'(RESET_LOAD);
    end else begin
      if (wr_data) data_q <= bus_wdata[CNT_W-1:0];
      if (wr_cnt)      cnt_q <= bus_wdata[CNT_W-1:0];
      else if (expire) cnt_q <= data_q;
      else if (tick)   cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_flag <= 1'b0;
      rst_left <= '0;
    end else begin
      if (expire && r_irq_en) irq_flag <= 1'b1;
      else if (wr_clr)        irq_flag <= 1'b0;
      if (expire && r_rst_en)   rst_left <= RC_W'(RST_CYCLES);
      else if (rst_left != '0) rst_left <= rst_left - 1'b1;
    end
  end

  always_comb begin
    case (bus_addr[3:2])
      2'd0:    bus_rdata = {15'b0, r_dbgmask, (8)'(r_pre), 2'b0, r_en, r_div, r_irq_en, 1'b0, r_rst_en};
      2'd1:    bus_rdata = 32'(data_q);
      2'd2:    bus_rdata = 32'(cnt_q);
      default: bus_rdata = '0;
    endcase
  end
endmodule

module wdt_prescaled_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [3:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic [31:0]      bus_rdata,
  input logic             dbg_ack,
  input logic             irq,
  input logic             rst_req,
  input logic             r_en,
  input logic             r_dbgmask,
  input logic             irq_flag,
  input logic [CNT_W-1:0] cnt_q
);
  logic cnt_w, clr_w;
  assign cnt_w = bus_sel && bus_wr && bus_addr[3:2] == 2'd2;
  assign clr_w = bus_sel && bus_wr && bus_addr[3:2] == 2'd3;

  assert_dbg_silence_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (r_dbgmask && dbg_ack) |-> (!irq && !rst_req));

  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !clr_w) |=> irq_flag);

  assert_keepalive_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_w |=> (cnt_q == $past(bus_wdata[CNT_W-1:0])));

  assert_frozen_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_en && !cnt_w) |=> $stable(cnt_q));

  assert_clear_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[3:2] == 2'd3) |-> (bus_rdata == 32'd0));
endmodule

bind wdt_prescaled wdt_prescaled_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/wdt_prescaled_tb.sv
module wdt_prescaled_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        dbg_ack = 1'b0;
  logic        irq, rst_req;
  int          checks = 0, errors = 0;

  always #4 clk = ~clk;

  wdt_prescaled u_dut (.*);

  function automatic logic [31:0] ctrl_word(input logic en, input logic [1:0] div,
      input logic [7:0] pre, input logic rst_en, input logic irq_en, input logic dbg);
    return {15'b0, dbg, pre, 2'b0, en, div, irq_en, 1'b0, rst_en};
  endfunction

  function automatic int period(input int p, input int s, input int n);
    return (n + 1) * (16 << s) * (p + 1);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic expiry_run(input int p, input int s, input int n);
    logic [31:0] v;
    int t = period(p, s, n);
    wr(4'h0, 32'd0);
    wr(4'h4, 32'(n));
    wr(4'h8, 32'(n));
    wr(4'hC, 32'd0);
    wr(4'h0, ctrl_word(1'b1, 2'(s), 8'(p), 1'b0, 1'b1, 1'b0));
    repeat (t - 1) @(posedge clk);
    #2 check("R3 irq before expiry", 32'(irq), 0);
    @(posedge clk); #2;
    check("R4 irq at expiry", 32'(irq), 1);
    check("R10 no reset request", 32'(rst_req), 0);
    rd(4'h8, v);
    check("R4 reload after expiry", v, 32'(n));
    wr(4'hC, 32'hDEAD);
    #1 check("R5 clear write", 32'(irq), 0);
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    int n;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    rd(4'h0, v); check("R1 control reset", v, 0);
    rd(4'h4, v); check("R1 reload reset", v, 32'h8000);
    rd(4'h8, v); check("R1 count reset", v, 32'h8000);
    check("R1 irq reset", 32'(irq), 0);
    check("R1 rst_req reset", 32'(rst_req), 0);

    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, v); check("R2 control fields", v, 32'h0001_FF3D);
    wr(4'h0, 32'd0);
    rd(4'hC, v); check("R2 clear reads zero", v, 0);

    // R8: partial prescale left behind, then full period on re-enable
    wr(4'h8, 32'd100);
    wr(4'h0, ctrl_word(1'b1, 2'd1, 8'd2, 1'b0, 1'b0, 1'b0));
    repeat (70) @(posedge clk);
    wr(4'h0, 32'd0);
    rd(4'h8, v);
    repeat (100) @(posedge clk);
    rd(4'h8, v2);
    check("R8 frozen count", v2, v);
    check("R8 frozen count value", v, 100);
    expiry_run(3, 0, 0);

    for (int i = 0; i < 12; i++) begin
      expiry_run(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)), int'($urandom_range(0, 3)));
    end
    expiry_run(0, 3, 1);

    // R5 sticky flag, R9 debug mask
    wr(4'h0, 32'd0);
    wr(4'h4, 32'd0); wr(4'h8, 32'd0);
    wr(4'h0, ctrl_word(1'b1, 2'd0, 8'd0, 1'b0, 1'b1, 1'b0));
    repeat (20) @(posedge clk);
    wr(4'h0, ctrl_word(1'b0, 2'd0, 8'd0, 1'b0, 1'b0, 1'b1));
    repeat (50) @(posedge clk);
    #2 check("R5 flag sticky", 32'(irq), 1);
    dbg_ack = 1'b1;
    #1 check("R9 irq muted", 32'(irq), 0);
    dbg_ack = 1'b0;
    #1 check("R9 flag kept", 32'(irq), 1);
    wr(4'hC, 32'd0);

    // R7 keepalive on a tick edge
    wr(4'h0, 32'd0);
    wr(4'h4, 32'd5); wr(4'h8, 32'd5);
    wr(4'h0, ctrl_word(1'b1, 2'd0, 8'd0, 1'b0, 1'b1, 1'b0));
    repeat (47) @(posedge clk);
    wr(4'h8, 32'd5);
    repeat (95) @(posedge clk);
    #2 check("R7 keepalive delays expiry", 32'(irq), 0);
    @(posedge clk); #2;
    check("R7 expiry after keepalive", 32'(irq), 1);
    wr(4'h0, 32'd0); wr(4'hC, 32'd0);

    // R10 irq disabled gives no flag
    wr(4'h4, 32'hFFFF); wr(4'h8, 32'd0);
    wr(4'h0, ctrl_word(1'b1, 2'd0, 8'd0, 1'b0, 1'b0, 1'b0));
    repeat (16) @(posedge clk);
    #2 check("R10 no flag when disabled", 32'(irq), 0);
    wr(4'h0, 32'd0);

    // R6 reset pulse width, R9 on reset output
    wr(4'h8, 32'd0);
    wr(4'h0, ctrl_word(1'b1, 2'd0, 8'd0, 1'b1, 1'b0, 1'b1));
    repeat (15) @(posedge clk);
    #2 check("R6 before expiry", 32'(rst_req), 0);
    @(posedge clk); #2;
    check("R6 rises at expiry", 32'(rst_req), 1);
    dbg_ack = 1'b1;
    #1 check("R9 reset muted", 32'(rst_req), 0);
    dbg_ack = 1'b0;
    #1;
    n = 0;
    while (rst_req && n < 300) begin
      n++;
      @(posedge clk); #2;
    end
    check("R6 pulse length", 32'(n), 128);
    wr(4'h0, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule